// File: doc/BRIEF.md
# Write-Read Ordering Guard

This block sits on the data side of a pipelined processor, between the stage that issues memory requests and the data bus. Left alone, the pipeline lets a younger read reach the bus ahead of an older write. For most memory this is harmless. For a peripheral where a write changes what a nearby register returns, it is not. The guard keeps a write and a later read in program order when both fall inside one programmable window of the 22-bit word address space. It also always keeps them in order when the two share the exact same address.

The window is set by two 16-bit configuration registers, a base and a span. Both are compared against the upper 16 bits of a word address, so the window starts on a 64-word boundary. Its size is 64 words times a power of two, from 64 words up to the whole space. Writes pass through a one-entry slot, which drives the bus write channel. Reads pass straight through when no hazard exists. A read that would overtake a hazardous held write is kept waiting until the bus has accepted that write.

Top module: `wr_order_guard`

## Requirements
- R1: After reset the base register reads 0x0100 and the span register reads 0x00FF, so the default window is word addresses 0x4000 through 0x7FFF. The selector `cfg_sel` picks the base register when 0 and the span register when 1, and `cfg_rdata` shows the selected register.
- R2: A configuration write (`cfg_we`=1) loads `cfg_wdata` into the selected register at the clock edge. The new value is used for region matching from the next cycle on. A read presented in the same cycle as the write is matched against the old value.
- R3: An address A is inside the window when (A[21:6] & ~span) equals (base & ~span).
- R4: While a write is held in the slot and both its address and the incoming read address are inside the window, `up_rd_ready` and `bus_rd_valid` are both 0.
- R5: While a held write has exactly the read's address, the read is stalled whatever the window registers hold.
- R6: A read is not stalled by a held write when the two addresses differ and at least one of them is outside the window.
- R7: The write slot holds one write. `up_wr_ready` is 1 exactly when the slot is empty or the bus is accepting the held write. `bus_wr_valid`, `bus_wr_addr` and `bus_wr_data` present the held write and stay stable until `bus_wr_ready` is 1.
- R8: The slot empties on the cycle after the bus accepts the held write, unless a new write is accepted in the same cycle. A read stalled only by that write reaches the bus with `bus_rd_addr` equal to `up_rd_addr` on the first cycle the slot is empty.
- R9: A write presented on the upstream write port in the same cycle as a read counts as older than the read. Such a write stalls the read under the same rules as a held write (R4, R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 1 | Register select: 0 base, 1 span |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Selected configuration register |
| up_wr_valid | input | 1 | Write request from the pipeline |
| up_wr_ready | output | 1 | Write request taken |
| up_wr_addr | input | 22 | Write word address |
| up_wr_data | input | 16 | Write data |
| up_rd_valid | input | 1 | Read request from the pipeline |
| up_rd_ready | output | 1 | Read request taken by the bus |
| up_rd_addr | input | 22 | Read word address |
| bus_wr_valid | output | 1 | Held write offered to the bus |
| bus_wr_ready | input | 1 | Bus accepts the write |
| bus_wr_addr | output | 22 | Held write address |
| bus_wr_data | output | 16 | Held write data |
| bus_rd_valid | output | 1 | Read offered to the bus |
| bus_rd_ready | input | 1 | Bus accepts the read |
| bus_rd_addr | output | 22 | Read address to the bus |

## Verification
The bench checks addresses at the window edges (0x803F against 0x8040 for a 64-word window). A design with an off-by-one in the mask would let the first of these overtake or wrongly stall the second. It places the held write and the read on opposite sides of the window, where a design that tested only one of the two addresses would stall needlessly. It also uses an exact-address pair outside the window, which a region-only design would let reorder. Further tests release the write while a read waits, which catches a design that forwards the read in the same cycle the write is accepted. They also reprogram the span under a waiting read, which exposes a design that applies configuration writes late or too early. A write and a read arriving together show whether the design wrongly treats the read as older.

// File: rtl/wrg_pkg.sv
package wrg_pkg;

    localparam int unsigned WRG_ADDR_W = 22;
    localparam int unsigned WRG_REG_W  = 16;
    localparam int unsigned WRG_DATA_W = 16;

    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_SPAN = 1'b1
    } cfg_sel_e;

    localparam logic [WRG_REG_W-1:0] BASE_RESET = 16'h0100;
    localparam logic [WRG_REG_W-1:0] SPAN_RESET = 16'h00FF;

endpackage

// File: rtl/wrg_cfg_regs.sv
module wrg_cfg_regs
    import wrg_pkg::*;
#(
    parameter int unsigned REG_W = WRG_REG_W,
    parameter logic [REG_W-1:0] BASE_INIT = BASE_RESET,
    parameter logic [REG_W-1:0] SPAN_INIT = SPAN_RESET
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] base,
    output logic [REG_W-1:0] span
);

    typedef struct packed {
        logic [REG_W-1:0] base;
        logic [REG_W-1:0] span;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            if (cfg_sel_e'(sel) == SEL_BASE) begin
                cfg_d.base = wdata;
            end else begin
                cfg_d.span = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.base <= BASE_INIT;
            cfg_q.span <= SPAN_INIT;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base  = cfg_q.base;
    assign span  = cfg_q.span;
    assign rdata = (cfg_sel_e'(sel) == SEL_BASE) ? cfg_q.base : cfg_q.span;

endmodule

// File: rtl/wrg_write_slot.sv
module wrg_write_slot
    import wrg_pkg::*;
#(
    parameter int unsigned ADDR_W = WRG_ADDR_W,
    parameter int unsigned DATA_W = WRG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;
    logic  take;

    always_comb begin
        slot_d   = slot_q;
        in_ready = !slot_q.valid || out_ready;
        take     = in_valid && in_ready;
        if (take) begin
            slot_d.valid = 1'b1;
            slot_d.addr  = in_addr;
            slot_d.data  = in_data;
        end else if (slot_q.valid && out_ready) begin
            slot_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign out_valid = slot_q.valid;
    assign out_addr  = slot_q.addr;
    assign out_data  = slot_q.data;

endmodule

// File: rtl/wrg_hazard.sv
module wrg_hazard
    import wrg_pkg::*;
#(
    parameter int unsigned ADDR_W   = WRG_ADDR_W,
    parameter int unsigned REG_W    = WRG_REG_W,
    parameter int unsigned NUM_CAND = 2
) (
    input  logic [REG_W-1:0]               base,
    input  logic [REG_W-1:0]               span,
    input  logic [ADDR_W-1:0]              rd_addr,
    input  logic [NUM_CAND-1:0]            cand_valid,
    input  logic [NUM_CAND-1:0][ADDR_W-1:0] cand_addr,
    output logic                           stall
);

    localparam int unsigned LOW_W = ADDR_W - REG_W;

    logic [REG_W-1:0]    keep;
    logic [REG_W-1:0]    base_m;
    logic                rd_in;
    logic [NUM_CAND-1:0] hit;

    always_comb begin
        keep   = ~span;
        base_m = base & keep;
        rd_in  = (rd_addr[ADDR_W-1:LOW_W] & keep) == base_m;
    end

    for (genvar i = 0; i < NUM_CAND; i++) begin : g_cand
        logic c_in;
        logic c_same;
        always_comb begin
            c_in   = (cand_addr[i][ADDR_W-1:LOW_W] & keep) == base_m;
            c_same = cand_addr[i] == rd_addr;
            hit[i] = cand_valid[i] && (c_same || (c_in && rd_in));
        end
    end

    assign stall = |hit;

endmodule

// File: rtl/wr_order_guard.sv
module wr_order_guard
    import wrg_pkg::*;
#(
    parameter int unsigned ADDR_W = WRG_ADDR_W,
    parameter int unsigned DATA_W = WRG_DATA_W,
    parameter int unsigned REG_W  = WRG_REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              up_wr_valid,
    output logic              up_wr_ready,
    input  logic [ADDR_W-1:0] up_wr_addr,
    input  logic [DATA_W-1:0] up_wr_data,
    input  logic              up_rd_valid,
    output logic              up_rd_ready,
    input  logic [ADDR_W-1:0] up_rd_addr,
    output logic              bus_wr_valid,
    input  logic              bus_wr_ready,
    output logic [ADDR_W-1:0] bus_wr_addr,
    output logic [DATA_W-1:0] bus_wr_data,
    output logic              bus_rd_valid,
    input  logic              bus_rd_ready,
    output logic [ADDR_W-1:0] bus_rd_addr
);

    localparam int unsigned NUM_CAND = 2;

    logic [REG_W-1:0]                base_q;
    logic [REG_W-1:0]                span_q;
    logic                            rd_stall;
    logic [NUM_CAND-1:0]             cand_valid;
    logic [NUM_CAND-1:0][ADDR_W-1:0] cand_addr;

    wrg_cfg_regs #(
        .REG_W (REG_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .base  (base_q),
        .span  (span_q)
    );

    wrg_write_slot #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (up_wr_valid),
        .in_ready  (up_wr_ready),
        .in_addr   (up_wr_addr),
        .in_data   (up_wr_data),
        .out_valid (bus_wr_valid),
        .out_ready (bus_wr_ready),
        .out_addr  (bus_wr_addr),
        .out_data  (bus_wr_data)
    );

    // candidate 0: held write, candidate 1: write arriving this cycle (older)
    always_comb begin
        cand_valid[0] = bus_wr_valid;
        cand_addr[0]  = bus_wr_addr;
        cand_valid[1] = up_wr_valid;
        cand_addr[1]  = up_wr_addr;
    end

    wrg_hazard #(
        .ADDR_W   (ADDR_W),
        .REG_W    (REG_W),
        .NUM_CAND (NUM_CAND)
    ) u_haz (
        .base       (base_q),
        .span       (span_q),
        .rd_addr    (up_rd_addr),
        .cand_valid (cand_valid),
        .cand_addr  (cand_addr),
        .stall      (rd_stall)
    );

    assign bus_rd_valid = up_rd_valid && !rd_stall;
    assign up_rd_ready  = bus_rd_ready && !rd_stall;
    assign bus_rd_addr  = up_rd_addr;

endmodule

// File: rtl/wr_order_guard_chk.sv
module wr_order_guard_chk #(
    parameter int unsigned ADDR_W = 22,
    parameter int unsigned REG_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_sel,
    input logic [REG_W-1:0]  cfg_wdata,
    input logic [REG_W-1:0]  base_q,
    input logic [REG_W-1:0]  span_q,
    input logic              up_wr_valid,
    input logic              up_wr_ready,
    input logic [ADDR_W-1:0] up_wr_addr,
    input logic              up_rd_valid,
    input logic              up_rd_ready,
    input logic [ADDR_W-1:0] up_rd_addr,
    input logic              bus_wr_valid,
    input logic              bus_wr_ready,
    input logic [ADDR_W-1:0] bus_wr_addr,
    input logic              bus_rd_valid,
    input logic [ADDR_W-1:0] bus_rd_addr
);

    assert_base_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_sel) |=> (base_q == $past(cfg_wdata)));

    assert_span_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel) |=> (span_q == $past(cfg_wdata)));

    assert_same_addr_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_valid && up_rd_valid && (up_rd_addr == bus_wr_addr)) |-> (!bus_rd_valid && !up_rd_ready));

    assert_slot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_valid && !bus_wr_ready) |=> (bus_wr_valid && $stable(bus_wr_addr)));

    assert_slot_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_valid && bus_wr_ready && !(up_wr_valid && up_wr_ready)) |=> !bus_wr_valid);

    assert_rd_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd_valid |-> (up_rd_valid && (bus_rd_addr == up_rd_addr)));

    assert_same_cycle_older_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_wr_valid && up_rd_valid && (up_rd_addr == up_wr_addr)) |-> !bus_rd_valid);

endmodule

bind wr_order_guard wr_order_guard_chk #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .base_q       (base_q),
    .span_q       (span_q),
    .up_wr_valid  (up_wr_valid),
    .up_wr_ready  (up_wr_ready),
    .up_wr_addr   (up_wr_addr),
    .up_rd_valid  (up_rd_valid),
    .up_rd_ready  (up_rd_ready),
    .up_rd_addr   (up_rd_addr),
    .bus_wr_valid (bus_wr_valid),
    .bus_wr_ready (bus_wr_ready),
    .bus_wr_addr  (bus_wr_addr),
    .bus_rd_valid (bus_rd_valid),
    .bus_rd_addr  (bus_rd_addr)
);

// File: tb/wr_order_guard_bench.sv
module wr_order_guard_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, cfg_sel;
    logic [15:0] cfg_wdata, cfg_rdata;
    logic        up_wr_valid, up_wr_ready;
    logic [21:0] up_wr_addr;
    logic [15:0] up_wr_data;
    logic        up_rd_valid, up_rd_ready;
    logic [21:0] up_rd_addr;
    logic        bus_wr_valid, bus_wr_ready;
    logic [21:0] bus_wr_addr;
    logic [15:0] bus_wr_data;
    logic        bus_rd_valid, bus_rd_ready;
    logic [21:0] bus_rd_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wr_order_guard u_wr_order_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .up_wr_valid(up_wr_valid), .up_wr_ready(up_wr_ready),
        .up_wr_addr(up_wr_addr), .up_wr_data(up_wr_data),
        .up_rd_valid(up_rd_valid), .up_rd_ready(up_rd_ready), .up_rd_addr(up_rd_addr),
        .bus_wr_valid(bus_wr_valid), .bus_wr_ready(bus_wr_ready),
        .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
        .bus_rd_valid(bus_rd_valid), .bus_rd_ready(bus_rd_ready), .bus_rd_addr(bus_rd_addr)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // drive at the falling edge, then let logic settle
    task automatic at_neg();
        @(negedge clk);
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_sel = 0; cfg_wdata = '0;
        up_wr_valid = 0; up_wr_addr = '0; up_wr_data = '0;
        up_rd_valid = 0; up_rd_addr = '0;
        bus_wr_ready = 0; bus_rd_ready = 1;
    endtask

    task automatic cfg_write(input logic sel, input logic [15:0] v);
        at_neg();
        cfg_we = 1; cfg_sel = sel; cfg_wdata = v;
        at_neg();
        cfg_we = 0;
    endtask

    // place a write into the slot while the bus is not accepting
    task automatic load_write(input logic [21:0] a, input logic [15:0] d);
        at_neg();
        bus_wr_ready = 0;
        up_wr_valid = 1; up_wr_addr = a; up_wr_data = d;
        at_neg();
        up_wr_valid = 0;
    endtask

    task automatic drain_write();
        at_neg();
        up_rd_valid = 0;
        bus_wr_ready = 1;
        at_neg();
        bus_wr_ready = 0;
    endtask

    task automatic probe_read(input string req, input logic [21:0] a, input logic exp_go);
        up_rd_valid = 1; up_rd_addr = a;
        settle();
        check(req, "bus_rd_valid", 32'(bus_rd_valid), 32'(exp_go));
        check(req, "up_rd_ready", 32'(up_rd_ready), 32'(exp_go));
        up_rd_valid = 0;
    endtask

    task automatic t_reset();
        at_neg();
        cfg_sel = 0; settle();
        check("R1", "base reset", 32'(cfg_rdata), 32'h0100);
        cfg_sel = 1; settle();
        check("R1", "span reset", 32'(cfg_rdata), 32'h00FF);
        check("R7", "slot empty after reset", 32'(bus_wr_valid), 32'd0);
        cfg_sel = 0;
    endtask

    task automatic t_slot();
        load_write(22'h04010, 16'hBEEF);
        settle();
        check("R7", "held valid", 32'(bus_wr_valid), 32'd1);
        check("R7", "held addr", 32'(bus_wr_addr), 32'h04010);
        check("R7", "held data", 32'(bus_wr_data), 32'hBEEF);
        up_wr_valid = 1; up_wr_addr = 22'h30000; settle();
        check("R7", "slot full not ready", 32'(up_wr_ready), 32'd0);
        bus_wr_ready = 1; settle();
        check("R7", "ready while bus accepts", 32'(up_wr_ready), 32'd1);
        bus_wr_ready = 0; up_wr_valid = 0; settle();
    endtask

    task automatic t_region();
        // slot holds 0x4010 (inside default window 0x4000..0x7FFF)
        at_neg();
        probe_read("R4", 22'h05000, 1'b0);
        probe_read("R4", 22'h07FFF, 1'b0);
        probe_read("R6", 22'h08000, 1'b1);
        probe_read("R6", 22'h03FFF, 1'b1);
    endtask

    task automatic t_release();
        // read waits during the accept cycle, goes the next cycle
        at_neg();
        up_rd_valid = 1; up_rd_addr = 22'h06000; bus_wr_ready = 1;
        settle();
        check("R8", "stalled during accept", 32'(bus_rd_valid), 32'd0);
        at_neg();
        bus_wr_ready = 0; settle();
        check("R8", "slot empty after accept", 32'(bus_wr_valid), 32'd0);
        check("R8", "read released", 32'(bus_rd_valid), 32'd1);
        check("R8", "read addr forwarded", 32'(bus_rd_addr), 32'h06000);
        up_rd_valid = 0;
    endtask

    task automatic t_exact();
        load_write(22'h09000, 16'h1234);
        probe_read("R6", 22'h09001, 1'b1);
        probe_read("R5", 22'h09000, 1'b0);
        drain_write();
        settle();
        probe_read("R5", 22'h09000, 1'b1);
    endtask

    task automatic t_reprogram();
        cfg_write(1'b0, 16'h0200);
        cfg_write(1'b1, 16'h0000);
        cfg_sel = 0; settle();
        check("R2", "base readback", 32'(cfg_rdata), 32'h0200);
        cfg_sel = 1; settle();
        check("R2", "span readback", 32'(cfg_rdata), 32'h0000);
        load_write(22'h08001, 16'h0001);
        probe_read("R3", 22'h0803F, 1'b0);
        probe_read("R3", 22'h08040, 1'b1);
        probe_read("R3", 22'h07FFF, 1'b1);
        drain_write();
    endtask

    task automatic t_cfg_timing();
        // restore default window, hold 0x4000, read 0x4100 waits
        cfg_write(1'b0, 16'h0100);
        cfg_write(1'b1, 16'h00FF);
        load_write(22'h04000, 16'h0002);
        up_rd_valid = 1; up_rd_addr = 22'h04100;
        cfg_we = 1; cfg_sel = 1; cfg_wdata = 16'h0000;
        settle();
        check("R2", "old span used same cycle", 32'(bus_rd_valid), 32'd0);
        at_neg();
        cfg_we = 0; settle();
        check("R2", "new span next cycle", 32'(bus_rd_valid), 32'd1);
        up_rd_valid = 0;
        drain_write();
        cfg_write(1'b1, 16'h00FF);
    endtask

    task automatic t_same_cycle();
        at_neg();
        up_wr_valid = 1; up_wr_addr = 22'h05555; bus_wr_ready = 0;
        probe_read("R9", 22'h06666, 1'b0);
        up_wr_valid = 1; up_wr_addr = 22'h20000;
        probe_read("R9", 22'h20000, 1'b0);
        up_wr_valid = 1;
        probe_read("R9", 22'h20001, 1'b1);
        up_wr_valid = 0;
        at_neg();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        at_neg();
        rst_n = 1;
        t_reset();
        t_slot();
        t_region();
        t_release();
        t_exact();
        t_reprogram();
        t_cfg_timing();
        t_same_cycle();
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule